// File: doc/BRIEF.md
# Shared Zero-Run and Set-Bit Counter

This block is a purely combinational counting unit for an integer execution datapath. From one operand and a two-bit operation code it returns one of three counts: the number of set bits in the operand, the length of the run of zero bits that starts at the most significant end, or the length of the run of zero bits that starts at the least significant end. The result is one bit wider than needed to index the operand, so a full-width count (32 for the default width) can be represented.

All three counts come out of a single ripple of one-bit accumulating stages. A front stage prepares a bit vector for that ripple. For the set-bit count it passes the operand through unchanged. For the trailing-zero count it inverts the operand. For the leading-zero count it reverses and inverts the operand, so that the zero run to be counted always begins at bit 0. For the two zero-run modes, a gating chain switches off every stage that follows the first bit that does not qualify. The unit therefore needs no separate priority encoder. Timing, pipelining and register-file connection belong to the surrounding datapath.

Top module: `bitcnt_unit`

## Requirements
- R1: With `op_sel_i` = 0, `count_o` equals the number of bits of `operand_i` that are 1.
- R2: With `op_sel_i` = 1, `count_o` equals the number of consecutive 0 bits of `operand_i` counted from bit WIDTH-1 downwards, stopping at the first 1 bit.
- R3: With `op_sel_i` = 2, `count_o` equals the number of consecutive 0 bits of `operand_i` counted from bit 0 upwards, stopping at the first 1 bit.
- R4: An all-zero operand gives WIDTH (32) for both `op_sel_i` = 1 and `op_sel_i` = 2.
- R5: With `op_sel_i` = 0, an all-ones operand gives WIDTH (32) and an all-zero operand gives 0.
- R6: With `op_sel_i` = 3, `count_o` is 0 whatever the operand holds.
- R7: `count_o` never exceeds WIDTH and depends only on the present inputs, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WIDTH (32) | Operand to be counted |
| op_sel_i | input | 2 | Operation code: 0 set bits, 1 leading zeros, 2 trailing zeros, 3 none |
| count_o | output | $clog2(WIDTH)+1 (6) | Resulting count, 0 to WIDTH |

## Verification
The operand is swept with a single one bit at every position. This places the end of the leading and trailing zero runs at each possible stage and shows whether the gating chain stops at the right place. A single zero at every position exercises set counts of WIDTH-1 and checks that the zero runs stay at length 0 or end at the lone zero's neighbour. All-zero and all-ones words cover the full-width results and the empty results. A stretch of pseudo-random words with mixed bit densities is applied under all four operation codes, which separates the set-bit count from the two zero-run counts and confirms that code 3 ignores the operand.

// File: rtl/bitcnt_pkg.sv
// Shared types for the set-bit / zero-run counting unit.
package bitcnt_pkg;

    // Operation codes carried on op_sel_i.
    typedef enum logic [1:0] {
        BC_SETBITS = 2'd0,
        BC_LEADZ   = 2'd1,
        BC_TRAILZ  = 2'd2,
        BC_IDLE    = 2'd3
    } bitcnt_op_e;

endpackage

// File: rtl/bitcnt_prep.sv
// bitcnt_prep: builds the vector that the shared counting ripple consumes.
// Set-bit mode passes the operand through. Trailing-zero mode inverts it.
// Leading-zero mode reverses and inverts it, so the run of interest always
// begins at bit 0. The idle code yields an all-zero vector.
// Assumes: W >= 2. Purely combinational.
module bitcnt_prep
    import bitcnt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] operand_i,
    input  bitcnt_op_e   op_i,
    output logic [W-1:0] vec_o,
    output logic         gated_o
);

    logic [W-1:0] reversed;

    // Mirror the operand bit order.
    for (genvar g = 0; g < W; g++) begin : g_rev
        assign reversed[g] = operand_i[W-1-g];
    end

    // Choose the vector to be counted for the requested operation.
    always_comb begin
        unique case (op_i)
            BC_SETBITS: vec_o = operand_i;
            BC_LEADZ:   vec_o = ~reversed;
            BC_TRAILZ:  vec_o = ~operand_i;
            default:    vec_o = '0;
        endcase
    end

    // The zero-run modes stop counting at the first non-qualifying bit.
    assign gated_o = (op_i == BC_LEADZ) || (op_i == BC_TRAILZ);

endmodule

// File: rtl/bitcnt_chain.sv
// bitcnt_chain: ripple of W one-bit accumulating stages starting at bit 0.
// Stage i adds vec_i[i] when its enable is high. Without gating every stage
// is enabled. With gating, stage i is enabled only when stage i-1 was
// enabled and its bit was 1, so the sum stops at the first 0 of vec_i.
// Assumes: CW bits can hold the value W. Purely combinational.
module bitcnt_chain #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec_i,
    input  logic          gated_i,
    output logic [CW-1:0] sum_o
);

    logic [W-1:0]  stage_en;
    logic [CW-1:0] partial [0:W];

    assign partial[0] = '0;

    for (genvar g = 0; g < W; g++) begin : g_stage
        // Enable of this stage from the previous one.
        if (g == 0) begin : g_first
            assign stage_en[g] = 1'b1;
        end else begin : g_next
            assign stage_en[g] = ~gated_i | (stage_en[g-1] & vec_i[g-1]);
        end
        // One-bit accumulation for this stage.
        assign partial[g+1] = partial[g] + {{(CW-1){1'b0}}, stage_en[g] & vec_i[g]};
    end

    assign sum_o = partial[W];

endmodule

// File: rtl/bitcnt_unit.sv
// bitcnt_unit: combinational set-bit, leading-zero and trailing-zero counter
// built on one shared ripple of one-bit adders.
// op_sel_i: 0 set bits, 1 leading zeros, 2 trailing zeros, 3 returns zero.
// Assumes: no clock; the caller registers the result when it needs to.
module bitcnt_unit
    import bitcnt_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [1:0]       op_sel_i,
    output logic [CW-1:0]    count_o
);

    bitcnt_op_e       op;
    logic [WIDTH-1:0] vec;
    logic             gated;

    // Decode the operation code.
    assign op = bitcnt_op_e'(op_sel_i);

    bitcnt_prep #(.W(WIDTH)) i_prep (
        .operand_i (operand_i),
        .op_i      (op),
        .vec_o     (vec),
        .gated_o   (gated)
    );

    bitcnt_chain #(.W(WIDTH), .CW(CW)) i_chain (
        .vec_i   (vec),
        .gated_i (gated),
        .sum_o   (count_o)
    );

endmodule

// File: rtl/bitcnt_unit_chk.sv
// bitcnt_unit_chk: immediate assertions on the ports of bitcnt_unit.
// The unit has no clock, so every check runs whenever its inputs settle.
module bitcnt_unit_chk #(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH) + 1
) (
    input logic [WIDTH-1:0] operand_i,
    input logic [1:0]       op_sel_i,
    input logic [CW-1:0]    count_o
);

    int cnt;

    // Port-level consistency checks.
    always_comb begin
        cnt = int'(count_o);
        if (!$isunknown({operand_i, op_sel_i, count_o})) begin
            AST_COUNT_RANGE: assert (cnt <= WIDTH); // R7
            AST_SETBITS_SUM: assert (op_sel_i != 2'd0 || cnt == $countones(operand_i)); // R1
            AST_LEADZ_STOP:  assert (op_sel_i != 2'd1 || cnt >= WIDTH || operand_i[WIDTH-1-cnt]); // R2
            AST_TRAILZ_STOP: assert (op_sel_i != 2'd2 || cnt >= WIDTH || operand_i[cnt]); // R3
            AST_ZERO_FULL:   assert (operand_i != '0 || !(op_sel_i == 2'd1 || op_sel_i == 2'd2) || cnt == WIDTH); // R4
            AST_IDLE_ZERO:   assert (op_sel_i != 2'd3 || cnt == 0); // R6
        end
    end

endmodule

bind bitcnt_unit bitcnt_unit_chk #(.WIDTH(WIDTH)) i_bitcnt_chk (
    .operand_i (operand_i),
    .op_sel_i  (op_sel_i),
    .count_o   (count_o)
);

// File: tb/test_bitcnt_unit.sv
// Bench for bitcnt_unit: sweeps structured and pseudo-random operands over
// all operation codes and compares against counts computed by loops here.
module test_bitcnt_unit;

    localparam int W  = 32;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic [W-1:0]  operand;
    logic [1:0]    op_sel;
    logic [CW-1:0] count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bitcnt_unit #(.WIDTH(W)) i_bitcnt_unit (
        .operand_i (operand),
        .op_sel_i  (op_sel),
        .count_o   (count)
    );

    // Reference count for one operand and operation code.
    function automatic int ref_count(logic [W-1:0] v, logic [1:0] op);
        int n = 0;
        case (op)
            2'd0: for (int i = 0; i < W; i++) n += int'(v[i]);
            2'd1: for (int i = W - 1; i >= 0; i--) begin
                      if (v[i]) break;
                      n++;
                  end
            2'd2: for (int i = 0; i < W; i++) begin
                      if (v[i]) break;
                      n++;
                  end
            default: n = 0;
        endcase
        return n;
    endfunction

    function automatic string tag_of(logic [1:0] op);
        case (op)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R6";
        endcase
    endfunction

    // Apply one stimulus and compare away from the clock edge.
    task automatic apply(logic [W-1:0] v, logic [1:0] op, string tag);
        int exp;
        @(posedge clk);
        operand = v;
        op_sel  = op;
        @(negedge clk);
        exp = ref_count(v, op);
        checks++;
        if (int'(count) != exp) begin
            errors++;
            $display("FAIL %s op=%0d operand=%h actual=%0d expected=%0d",
                     tag, op, v, count, exp);
        end
        checks++;
        if (int'(count) > W) begin // R7
            errors++;
            $display("FAIL R7 count above width actual=%0d expected<=%0d", count, W);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lfsr;
        operand = '0;
        op_sel  = 2'd3;
        // Initial state: idle code with zero operand reads zero (R6).
        apply('0, 2'd3, "R6");

        // Full-width and empty results (R4, R5).
        apply('0, 2'd1, "R4");
        apply('0, 2'd2, "R4");
        apply('0, 2'd0, "R5");
        apply('1, 2'd0, "R5");
        apply('1, 2'd1, "R2");
        apply('1, 2'd2, "R3");
        apply('1, 2'd3, "R6");

        // Single one at every position, every code.
        for (int p = 0; p < W; p++)
            for (int o = 0; o < 4; o++)
                apply(W'(1) << p, 2'(o), tag_of(2'(o)));

        // Single zero at every position, every code.
        for (int p = 0; p < W; p++)
            for (int o = 0; o < 4; o++)
                apply(~(W'(1) << p), 2'(o), tag_of(2'(o)));

        // Low-order ones of every length, then high-order ones.
        for (int p = 0; p <= W; p++) begin
            apply((p == W) ? '1 : ((W'(1) << p) - W'(1)), 2'd2, "R3");
            apply((p == W) ? '1 : ~((W'(1) << (W - p)) - W'(1)), 2'd1, "R2");
        end

        // Pseudo-random words of mixed density.
        lfsr = 32'hACE1_2357;
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] v;
            lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (k % 3)
                0:       v = lfsr;
                1:       v = lfsr & (lfsr >> 7) & (lfsr << 3);
                default: v = lfsr | (lfsr << 5);
            endcase
            for (int o = 0; o < 4; o++)
                apply(v, 2'(o), tag_of(2'(o)));
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule